// File: doc/BRIEF.md
# Accumulator Compare and Right-Shift Unit

This block is the flag and shift slice of a multiply-accumulate coprocessor. It keeps a 40-bit accumulator, built from an 8-bit guard extension over a 16-bit high word and a 16-bit low word, and a 16-bit status word. Each clock it executes at most one command taken from a 3-bit opcode. The commands are: load the accumulator, load the status word, compare, logical right shift and arithmetic right shift.

A compare subtracts a sign-extended 40-bit operand from the accumulator. It reports negative, zero and borrow, and it never writes the accumulator. Both right shifts always act on the full 40 bits and are never clamped. The extension-in-use flag is recomputed from the shifted value, and the saturation-mode input has no effect on that result.

The reset input is asserted asynchronously and released through a two-stage synchronizer. Commands are therefore accepted from the third rising edge after `rst_n` goes high.

Top module: `acc_cmpshift_unit`

## Requirements
- R1: While reset is active, and after it, until the first command is executed, the accumulator reads 0 and the status word reads 0.
- R2: Opcode 1 loads the accumulator with {ext_in, word_hi, word_lo}. The status word is unchanged.
- R3: Opcode 2 writes word_lo into all 16 bits of the status word. The accumulator is unchanged.
- R4: Opcode 3 (compare) leaves the accumulator unchanged. Its operand is {word_hi, word_lo}, sign-extended from bit 31 to 40 bits.
- R5: A compare sets status bit 0 (N) to bit 39 of (accumulator − operand) mod 2^40. It sets bit 1 (Z) when that difference is zero, and bit 2 (C) when the accumulator is below the operand as unsigned 40-bit values (the borrow). All other status bits, including bit 3, are kept. For example, accumulator 0x00_0007_0000 compared against 0x00_0006_0000 gives C = 0.
- R6: Opcode 4 shifts the accumulator right by shamt, filling with zeros. Counts 0 to 8 are honoured, and any count above 8 acts as 8.
- R7: Opcode 5 shifts the accumulator right in the same way, filling with copies of bit 39.
- R8: After either shift, status bit 3 (E) is 1 exactly when bits 39..31 of the result are not all equal. N is set to bit 39 of the result, and Z is set when the result is zero. C and bits 15..4 are kept. For example, 0x7F_5555_5555 shifted right by one gives 0x3F_AAAA_AAAA with E = 1.
- R9: sat_mode has no effect on the shift result or on any flag.
- R10: Opcode 0, and the unused opcodes 6 and 7, change neither the accumulator nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command opcode (0 none, 1 load acc, 2 load status, 3 compare, 4 logical shift, 5 arithmetic shift) |
| word_lo | input | 16 | Low operand word / status load value |
| word_hi | input | 16 | High operand word |
| ext_in | input | 8 | Extension byte for accumulator load |
| shamt | input | 4 | Right shift count |
| sat_mode | input | 1 | Saturation mode control |
| acc_out | output | 40 | Accumulator contents |
| stat_out | output | 16 | Status word |

## Verification
Both the accumulator and the status word are outputs, so any wrong internal state appears at a port one clock after the command that caused it. A reversed subtraction flips C and N on the first unequal compare. A compare that writes the accumulator shows up in acc_out immediately. A wrong shift fill or count clamp is visible in the very next accumulator value. An E flag that is gated by sat_mode differs on the first shift that leaves significant bits in the extension while sat_mode is high.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int ACC_W  = 40;
  localparam int EXT_W  = 8;
  localparam int WORD_W = 16;
  localparam int MAX_SH = 8;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int OPC_W  = 3;

  localparam int FLG_N = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 2;
  localparam int FLG_E = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 3'd0,
    OP_LDA  = 3'd1,
    OP_LDS  = 3'd2,
    OP_CMP  = 3'd3,
    OP_SHRL = 3'd4,
    OP_SHRA = 3'd5
  } acs_op_e;
endpackage

// File: rtl/acs_cmp.sv
module acs_cmp #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] opnd,
  output logic             neg,
  output logic             zero,
  output logic             borrow
);
  logic [ACC_W:0] wide_diff;

  always_comb begin
    wide_diff = {1'b0, acc} - {1'b0, opnd};
    neg       = wide_diff[ACC_W-1];
    zero      = (wide_diff[ACC_W-1:0] == '0);
    borrow    = wide_diff[ACC_W];
  end
endmodule

// File: rtl/acs_shift.sv
module acs_shift #(
  parameter int ACC_W  = 40,
  parameter int MAX_SH = 8,
  parameter int SH_W   = 4
) (
  input  logic [ACC_W-1:0] din,
  input  logic [SH_W-1:0]  cnt_raw,
  input  logic             arith,
  output logic [ACC_W-1:0] dout
);
  localparam logic [SH_W-1:0] CNT_MAX = SH_W'(MAX_SH);

  logic [SH_W-1:0]  cnt;
  logic             fill;
  logic [ACC_W-1:0] stg [0:SH_W];

  always_comb begin
    cnt  = (cnt_raw > CNT_MAX) ? CNT_MAX : cnt_raw;
    fill = arith & din[ACC_W-1];
  end

  assign stg[0] = din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int DIST = 1 << i;
    always_comb begin
      if (cnt[i]) stg[i+1] = {{DIST{fill}}, stg[i][ACC_W-1:DIST]};
      else        stg[i+1] = stg[i];
    end
  end

  assign dout = stg[SH_W];
endmodule

// File: rtl/acs_flags.sv
module acs_flags
  import acs_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int EXT_W  = 8,
  parameter int WORD_W = 16
) (
  input  acs_op_e           op,
  input  logic [WORD_W-1:0] stat_q,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              cmp_neg,
  input  logic              cmp_zero,
  input  logic              cmp_borrow,
  input  logic [ACC_W-1:0]  sh_res,
  output logic [WORD_W-1:0] stat_d,
  output logic              stat_en
);
  localparam int TOP_W = EXT_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             ext_used;

  always_comb begin
    top_bits = sh_res[ACC_W-1 -: TOP_W];
    ext_used = !((top_bits == '0) || (top_bits == '1));
    stat_d   = stat_q;
    stat_en  = 1'b0;
    case (op)
      OP_LDS: begin
        stat_d  = ld_word;
        stat_en = 1'b1;
      end
      OP_CMP: begin
        stat_d[FLG_N] = cmp_neg;
        stat_d[FLG_Z] = cmp_zero;
        stat_d[FLG_C] = cmp_borrow;
        stat_en       = 1'b1;
      end
      OP_SHRL, OP_SHRA: begin
        stat_d[FLG_N] = sh_res[ACC_W-1];
        stat_d[FLG_Z] = (sh_res == '0);
        stat_d[FLG_E] = ext_used;
        stat_en       = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_cmpshift_unit.sv
module acc_cmpshift_unit
  import acs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    cmd_op,
  input  logic [WORD_W-1:0]   word_lo,
  input  logic [WORD_W-1:0]   word_hi,
  input  logic [EXT_W-1:0]    ext_in,
  input  logic [SH_W-1:0]     shamt,
  input  logic                sat_mode,
  output logic [ACC_W-1:0]    acc_out,
  output logic [WORD_W-1:0]   stat_out
);
  localparam int OPND_LO = 2 * WORD_W;
  localparam int SX_W    = ACC_W - OPND_LO;
  localparam int TOP_W   = EXT_W + 1;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  acs_op_e           op;
  logic [ACC_W-1:0]  acc_q, acc_d, opnd_x, sh_res;
  logic              acc_en;
  logic [WORD_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic              cmp_neg, cmp_zero, cmp_borrow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign op     = acs_op_e'(cmd_op);
  assign opnd_x = {{SX_W{word_hi[WORD_W-1]}}, word_hi, word_lo};

  acs_cmp #(.ACC_W(ACC_W)) i_cmp (
    .acc(acc_q), .opnd(opnd_x),
    .neg(cmp_neg), .zero(cmp_zero), .borrow(cmp_borrow)
  );

  acs_shift #(.ACC_W(ACC_W), .MAX_SH(MAX_SH), .SH_W(SH_W)) i_shift (
    .din(acc_q), .cnt_raw(shamt), .arith(op == OP_SHRA), .dout(sh_res)
  );

  acs_flags #(.ACC_W(ACC_W), .EXT_W(EXT_W), .WORD_W(WORD_W)) i_flags (
    .op(op), .stat_q(stat_q), .ld_word(word_lo),
    .cmp_neg(cmp_neg), .cmp_zero(cmp_zero), .cmp_borrow(cmp_borrow),
    .sh_res(sh_res), .stat_d(stat_d), .stat_en(stat_en)
  );

  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    case (op)
      OP_LDA: begin
        acc_d  = {ext_in, word_hi, word_lo};
        acc_en = 1'b1;
      end
      OP_SHRL, OP_SHRA: begin
        acc_d  = sh_res;
        acc_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign acc_out  = acc_q;
  assign stat_out = stat_q;

  // R4: compare never writes the accumulator
  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op == OP_CMP) |=> $stable(acc_q));

  // R5: borrow is the unsigned accumulator-below-operand relation
  assert_cmp_borrow_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op == OP_CMP) |=> (stat_q[FLG_C] == ($past(acc_q) < $past(opnd_x))));

  // R5: compare keeps E
  assert_cmp_keep_e_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op == OP_CMP) |=> $stable(stat_q[FLG_E]));

  // R8 and R9: E after a shift matches the stored result even with saturation on
  assert_shift_e_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((cmd_op == OP_SHRL || cmd_op == OP_SHRA) && (sat_mode || !sat_mode)) |=>
      (stat_q[FLG_E] == !((acc_q[ACC_W-1 -: TOP_W] == '0) || (acc_q[ACC_W-1 -: TOP_W] == '1))));

  // R9: saturation never stops a shift from moving the extension
  assert_shift_nosat_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((cmd_op == OP_SHRL) && sat_mode && (shamt != '0)) |=> (acc_q[ACC_W-1] == 1'b0));

  // R10: idle opcodes hold all state
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_op == 3'd0 || cmd_op == 3'd6 || cmd_op == 3'd7) |=> ($stable(acc_q) && $stable(stat_q)));
endmodule

// File: tb/test_acc_cmpshift_unit.sv
module test_acc_cmpshift_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_op;
  logic [15:0] word_lo, word_hi;
  logic [7:0]  ext_in;
  logic [3:0]  shamt;
  logic        sat_mode;
  logic [39:0] acc_out;
  logic [15:0] stat_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [39:0] m_acc;
  logic [15:0] m_st;

  always #10 clk = ~clk;

  acc_cmpshift_unit i_acc_cmpshift_unit (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .word_lo(word_lo), .word_hi(word_hi),
    .ext_in(ext_in), .shamt(shamt), .sat_mode(sat_mode),
    .acc_out(acc_out), .stat_out(stat_out)
  );

  task automatic chk40(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s acc actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ext_sig(logic [39:0] v);
    return !((v[39:31] == 9'h000) || (v[39:31] == 9'h1FF));
  endfunction

  task automatic model(logic [2:0] op, logic [15:0] lo, logic [15:0] hi, logic [7:0] ex,
                       logic [3:0] sh);
    logic [39:0] opx;
    logic [39:0] d;
    int k;
    opx = {{8{hi[15]}}, hi, lo};
    k = (sh > 8) ? 8 : int'(sh);
    case (op)
      3'd1: m_acc = {ex, hi, lo};
      3'd2: m_st = lo;
      3'd3: begin
        d = m_acc - opx;
        m_st[0] = d[39];
        m_st[1] = (d == 0);
        m_st[2] = (m_acc < opx);
      end
      3'd4, 3'd5: begin
        for (int j = 0; j < k; j++)
          m_acc = {(op == 3'd5) ? m_acc[39] : 1'b0, m_acc[39:1]};
        m_st[0] = m_acc[39];
        m_st[1] = (m_acc == 0);
        m_st[3] = ext_sig(m_acc);
      end
      default: ;
    endcase
  endtask

  task automatic run(string tag, logic [2:0] op, logic [15:0] lo, logic [15:0] hi,
                     logic [7:0] ex, logic [3:0] sh, logic sat);
    @(negedge clk);
    cmd_op = op; word_lo = lo; word_hi = hi; ext_in = ex; shamt = sh; sat_mode = sat;
    model(op, lo, hi, ex, sh);
    @(posedge clk);
    #2 cmd_op = 3'd0;
    @(negedge clk);
    chk40(tag, acc_out, m_acc);
    chk16(tag, stat_out, m_st);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_op = 3'd0; word_lo = '0; word_hi = '0; ext_in = '0;
    shamt = '0; sat_mode = 1'b0;
    m_acc = '0; m_st = '0;
    repeat (3) @(negedge clk);
    chk40("R1 in reset", acc_out, 40'h0);
    chk16("R1 in reset", stat_out, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk40("R1 after release", acc_out, 40'h0);
    chk16("R1 after release", stat_out, 16'h0);

    // R2 load, then R4/R5 compare 0x70000 vs 0x60000: C must be clear
    run("R2 load", 3'd1, 16'h0000, 16'h0007, 8'h00, 4'd0, 1'b0);
    run("R4 R5 cmp ge", 3'd3, 16'h0000, 16'h0006, 8'h00, 4'd0, 1'b0);
    chk40("R4 acc held", acc_out, 40'h00_0007_0000);
    checks++;
    if (stat_out[2] !== 1'b0) begin
      errors++; $display("FAIL R5 C actual=%b expected=0", stat_out[2]);
    end
    run("R5 cmp lt", 3'd3, 16'h0000, 16'h0008, 8'h00, 4'd0, 1'b0);
    chk16("R5 lt flags", stat_out & 16'h0007, 16'h0005);
    run("R5 cmp eq", 3'd3, 16'h0000, 16'h0007, 8'h00, 4'd0, 1'b0);
    chk16("R5 eq flags", stat_out & 16'h0007, 16'h0002);
    run("R4 cmp neg operand", 3'd3, 16'h0000, 16'hFFFF, 8'h00, 4'd0, 1'b0);

    // R3 status load, compare keeps E and upper bits
    run("R3 lds", 3'd2, 16'hFFF8, 16'h1234, 8'h00, 4'd0, 1'b0);
    run("R5 keep E", 3'd3, 16'h0000, 16'h0001, 8'h00, 4'd0, 1'b0);
    chk16("R5 keep upper", stat_out & 16'hFFF8, 16'hFFF8);

    // R8 R9: example shift with saturation enabled and disabled
    run("R2 load 7F", 3'd1, 16'h5555, 16'h5555, 8'h7F, 4'd0, 1'b0);
    run("R9 shrl sat on", 3'd4, 16'h0, 16'h0, 8'h0, 4'd1, 1'b1);
    chk40("R8 example", acc_out, 40'h3F_AAAA_AAAA);
    checks++;
    if (stat_out[3] !== 1'b1) begin
      errors++; $display("FAIL R8 E actual=%b expected=1", stat_out[3]);
    end
    run("R2 reload 7F", 3'd1, 16'h5555, 16'h5555, 8'h7F, 4'd0, 1'b0);
    run("R9 shrl sat off", 3'd4, 16'h0, 16'h0, 8'h0, 4'd1, 1'b0);
    chk40("R9 same result", acc_out, 40'h3F_AAAA_AAAA);

    // R7 arithmetic fill, R6 clamp and zero count
    run("R2 load neg", 3'd1, 16'h0000, 16'h0000, 8'h80, 4'd0, 1'b0);
    run("R7 shra 4", 3'd5, 16'h0, 16'h0, 8'h0, 4'd4, 1'b1);
    chk40("R7 fill", acc_out, 40'hF8_0000_0000);
    run("R6 shrl clamp", 3'd4, 16'h0, 16'h0, 8'h0, 4'd15, 1'b0);
    chk40("R6 clamp", acc_out, 40'h00_F800_0000);
    run("R6 shrl zero", 3'd4, 16'h0, 16'h0, 8'h0, 4'd0, 1'b0);
    run("R8 shra small", 3'd5, 16'h0, 16'h0, 8'h0, 4'd8, 1'b1);

    // R10 idle opcodes
    run("R10 nop", 3'd0, 16'hFFFF, 16'hFFFF, 8'hFF, 4'd3, 1'b1);
    run("R10 op6", 3'd6, 16'hFFFF, 16'hFFFF, 8'hFF, 4'd3, 1'b1);
    run("R10 op7", 3'd7, 16'hFFFF, 16'hFFFF, 8'hFF, 4'd3, 1'b0);

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      run("R2 R3 R5 R6 R7 R8 mixed", 3'($urandom_range(0, 7)), 16'($urandom),
          16'($urandom), 8'($urandom), 4'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule